// File: doc/BRIEF.md
# Video Sync and Clamp Timing Controller

This block sits in the pixel clock domain of a video capture front end. It receives a raw horizontal sync, an optional external clamp strobe and an optional coast strobe. All three pass through a synchronizer first. A control bit picks which Hsync transition is the leading, timing-bearing edge. The other transition is the trailing edge.

From the leading edge the block regenerates a horizontal sync pulse with a programmable width and output polarity. Its latency from input sample to output is fixed, so it lines up with the pixel data path. From the trailing edge it can count out an internal clamp window: a delay first, then a duration. Alternatively, the clamp window can follow the external clamp pin with a selectable sense. The coast input, with a selectable sense, becomes an active-high hold request for the clock generator.

A four-entry write port holds the control bits, the pulse width, the clamp delay and the clamp duration.

Top module: `sync_clamp_ctrl`

## Requirements
- R1: After a synchronous reset, all outputs are 0 and the registers hold their reset values: control = 0x1A, width = 16, clamp delay = 4, clamp duration = 8.
- R2: Control bit 0 selects the leading Hsync edge. With 0 the falling edge leads and the rising edge trails; with 1 the roles swap. Only the leading edge starts an output pulse.
- R3: The input level is sampled on clock edge m and forms a leading edge. The output pulse is active after edges m+2 through m+W+1, where W is the width register (address 1). A width of 0 produces no pulse.
- R4: Control bit 1 sets the output sense: 1 means active high, 0 means active low (idle high).
- R5: A leading edge that arrives while a pulse is running reloads the full width, which stretches the pulse.
- R6: With control bit 2 = 0, a trailing edge sampled on edge m makes clamp_out high after edges m+2+D through m+1+D+L. D is the delay (address 2) and L is the duration (address 3).
- R7: A clamp delay of 0 starts the window one cycle after the edge is detected. A duration of 0 gives no clamp window, and it cancels a window that is already running.
- R8: A trailing edge that arrives while an internal clamp sequence runs restarts the sequence from its delay phase.
- R9: With control bit 2 = 1, clamp_out follows clamp_in two cycles late. It is active when clamp_in equals control bit 3. With bit 2 = 0, clamp_in has no effect on clamp_out.
- R10: coast_out is 1, two cycles after the sample, when coast_in equals control bit 4. Bit 4 resets to 1.
- R11: On a write strobe, cfg_addr selects the register: 0 control (wdata bits 4:0), 1 width, 2 clamp delay, 3 clamp duration. A write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| hsync_in | input | 1 | Raw horizontal sync |
| clamp_in | input | 1 | External clamp strobe |
| coast_in | input | 1 | External coast strobe |
| hsync_out | output | 1 | Regenerated horizontal sync |
| clamp_out | output | 1 | Clamp window |
| coast_out | output | 1 | Active-high clock generator hold request |

## Verification
The hardest case to reach is a trailing edge that lands inside a clamp sequence still in progress, whether in its delay phase or its hold phase. Close behind it is a leading edge landing inside a running output pulse. The stimulus reaches both by programming a long delay and duration, or a long width, and then driving a sync period shorter than that span. Dedicated phases also cover zero delay and zero duration. A behavioural model in the bench tracks sequence age against latched settings and is compared with every output on every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef struct packed {
    logic coast_pol;     // bit 4
    logic clamp_ext_pol; // bit 3
    logic clamp_ext_en;  // bit 2
    logic hs_out_pol;    // bit 1
    logic hs_in_pol;     // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 5'b11010;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_WIDTH = 2'd1;
  localparam logic [1:0] ADDR_DELAY = 2'd2;
  localparam logic [1:0] ADDR_DUR   = 2'd3;

  typedef enum logic [1:0] {CL_IDLE, CL_DELAY, CL_HOLD} clamp_st_e;
endpackage

// File: rtl/sc_regs.sv
module sc_regs
  import sc_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int HS_WIDTH_RST = 16,
  parameter int CL_DELAY_RST = 4,
  parameter int CL_DUR_RST   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] hs_width,
  output logic [CNT_W-1:0] cl_delay,
  output logic [CNT_W-1:0] cl_dur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= CTRL_RST;
      hs_width <= CNT_W'(HS_WIDTH_RST);
      cl_delay <= CNT_W'(CL_DELAY_RST);
      cl_dur   <= CNT_W'(CL_DUR_RST);
    end else if (we) begin
      case (addr)
        ADDR_CTRL:  ctrl     <= ctrl_t'(wdata[4:0]);
        ADDR_WIDTH: hs_width <= wdata;
        ADDR_DELAY: cl_delay <= wdata;
        default:    cl_dur   <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] pipe [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur  = pipe[STAGES-1];
  assign prev = pipe[STAGES];
endmodule

// File: rtl/sc_pulse.sv
module sc_pulse #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  input  logic             pol,
  output logic             pulse_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (start)            cnt_nxt = width;
    else if (cnt_o != '0) cnt_nxt = cnt_o - 1'b1;
    else                  cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      cnt_o   <= cnt_nxt;
      pulse_o <= (cnt_nxt != '0) ~^ pol;
    end
  end
endmodule

// File: rtl/sc_clamp.sv
module sc_clamp
  import sc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] dur,
  output logic             hold_nxt,
  output logic             busy
);
  clamp_st_e        st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (trig) begin
      if (dur == '0) begin
        st_nxt  = CL_IDLE;
        cnt_nxt = '0;
      end else if (delay == '0) begin
        st_nxt  = CL_HOLD;
        cnt_nxt = dur;
      end else begin
        st_nxt  = CL_DELAY;
        cnt_nxt = delay;
      end
    end else begin
      case (st)
        CL_DELAY: begin
          if (cnt <= CNT_W'(1)) begin
            st_nxt  = (dur == '0) ? CL_IDLE : CL_HOLD;
            cnt_nxt = dur;
          end else begin
            cnt_nxt = cnt - 1'b1;
          end
        end
        CL_HOLD: begin
          if (cnt <= CNT_W'(1)) begin
            st_nxt  = CL_IDLE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt - 1'b1;
          end
        end
        default: begin
          st_nxt  = CL_IDLE;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CL_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  assign hold_nxt = (st_nxt == CL_HOLD);
  assign busy     = (st != CL_IDLE);
endmodule

// File: rtl/sync_clamp_ctrl.sv
module sync_clamp_ctrl
  import sc_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int HS_WIDTH_RST = 16,
  parameter int CL_DELAY_RST = 4,
  parameter int CL_DUR_RST   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             hsync_in,
  input  logic             clamp_in,
  input  logic             coast_in,
  output logic             hsync_out,
  output logic             clamp_out,
  output logic             coast_out
);
  localparam int IDX_HS = 0;
  localparam int IDX_CL = 1;
  localparam int IDX_CO = 2;
  localparam int NSIG   = 3;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] hs_width, cl_delay, cl_dur, hs_cnt;
  logic [NSIG-1:0]  sy_cur, sy_prev;
  logic             hs_rise, hs_fall, hs_lead, hs_trail;
  logic             cl_hold_nxt, cl_busy;

  sc_regs #(
    .CNT_W(CNT_W), .HS_WIDTH_RST(HS_WIDTH_RST),
    .CL_DELAY_RST(CL_DELAY_RST), .CL_DUR_RST(CL_DUR_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .hs_width(hs_width), .cl_delay(cl_delay), .cl_dur(cl_dur)
  );

  sc_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .din({coast_in, clamp_in, hsync_in}),
    .cur(sy_cur), .prev(sy_prev)
  );

  assign hs_rise  =  sy_cur[IDX_HS] & ~sy_prev[IDX_HS];
  assign hs_fall  = ~sy_cur[IDX_HS] &  sy_prev[IDX_HS];
  assign hs_lead  = ctrl.hs_in_pol ? hs_rise : hs_fall;
  assign hs_trail = ctrl.hs_in_pol ? hs_fall : hs_rise;

  sc_pulse #(.CNT_W(CNT_W)) pulse_i (
    .clk(clk), .rst(rst), .start(hs_lead), .width(hs_width),
    .pol(ctrl.hs_out_pol), .pulse_o(hsync_out), .cnt_o(hs_cnt)
  );

  sc_clamp #(.CNT_W(CNT_W)) clamp_i (
    .clk(clk), .rst(rst), .trig(hs_trail), .delay(cl_delay), .dur(cl_dur),
    .hold_nxt(cl_hold_nxt), .busy(cl_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_out <= 1'b0;
      coast_out <= 1'b0;
    end else begin
      clamp_out <= ctrl.clamp_ext_en ? (sy_cur[IDX_CL] ~^ ctrl.clamp_ext_pol)
                                     : cl_hold_nxt;
      coast_out <= sy_cur[IDX_CO] ~^ ctrl.coast_pol;
    end
  end
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hs_lead,
  input logic             hs_trail,
  input logic [CNT_W-1:0] hs_cnt,
  input logic [CNT_W-1:0] hs_width,
  input logic             out_pol,
  input logic             hsync_out,
  input logic [CNT_W-1:0] clamp_dur,
  input logic             clamp_busy
);
  // R2
  lead_trail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hs_lead, hs_trail}));

  // R3
  width_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!hs_lead && hs_cnt != '0) |=> (hs_cnt == $past(hs_cnt) - 1'b1));

  // R5
  lead_reload_chk: assert property (@(posedge clk) disable iff (rst)
    hs_lead |=> (hs_cnt == $past(hs_width)));

  // R4
  out_sense_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(out_pol) |-> (hsync_out == ((hs_cnt != '0) ~^ out_pol)));

  // R8
  clamp_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_trail && clamp_dur != '0) |=> clamp_busy);
endmodule

bind sync_clamp_ctrl sc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .hs_lead(hs_lead), .hs_trail(hs_trail),
  .hs_cnt(hs_cnt), .hs_width(hs_width), .out_pol(ctrl.hs_out_pol),
  .hsync_out(hsync_out), .clamp_dur(cl_dur), .clamp_busy(cl_busy)
);

// File: tb/sync_clamp_ctrl_tb_top.sv
module sync_clamp_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       hsync_in = 1'b1;
  logic       clamp_in = 1'b0;
  logic       coast_in = 1'b0;
  logic       hsync_out, clamp_out, coast_out;

  int    n_total = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    chk_en  = 1'b0;
  bit    done    = 1'b0;

  always #5 clk = ~clk;

  sync_clamp_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync_in(hsync_in), .clamp_in(clamp_in),
    .coast_in(coast_in), .hsync_out(hsync_out), .clamp_out(clamp_out),
    .coast_out(coast_out)
  );

  // Reference model: sample history, remaining pulse length, clamp age.
  bit m_hs[$], m_cl[$], m_co[$];
  int m_ctrl, m_width, m_delay, m_dur;
  int hrem, c_age, c_d, c_u;
  bit c_act;
  bit e_hs, e_cl, e_co;

  always @(posedge clk) begin
    if (rst) begin
      m_hs = '{0, 0, 0, 0}; m_cl = '{0, 0, 0, 0}; m_co = '{0, 0, 0, 0};
      m_ctrl = 'h1A; m_width = 16; m_delay = 4; m_dur = 8;
      hrem = 0; c_act = 0; c_age = 0; c_d = 0; c_u = 0;
      e_hs = 0; e_cl = 0; e_co = 0;
    end else begin
      bit in_pol, lead, trail, newer, older;
      m_hs.push_front(hsync_in); void'(m_hs.pop_back());
      m_cl.push_front(clamp_in); void'(m_cl.pop_back());
      m_co.push_front(coast_in); void'(m_co.pop_back());
      in_pol = m_ctrl[0];
      newer = m_hs[2]; older = m_hs[3];
      lead  = in_pol ? (newer && !older) : (!newer && older);
      trail = in_pol ? (!newer && older) : (newer && !older);
      if (lead) hrem = m_width;
      else if (hrem > 0) hrem--;
      e_hs = (hrem > 0) ? m_ctrl[1] : !m_ctrl[1];
      if (trail) begin
        c_act = (m_dur != 0); c_age = 0; c_d = m_delay; c_u = m_dur;
      end else if (c_act) begin
        c_age++;
        if (c_age >= c_d + c_u) c_act = 0;
      end
      if (m_ctrl[2]) e_cl = (m_cl[2] == m_ctrl[3]);
      else           e_cl = c_act && (c_age >= c_d);
      e_co = (m_co[2] == m_ctrl[4]);
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_ctrl  = cfg_wdata & 8'h1F;
          2'd1: m_width = cfg_wdata;
          2'd2: m_delay = cfg_wdata;
          default: m_dur = cfg_wdata;
        endcase
      end
    end
  end

  task automatic check1(string what, logic act, logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check1("hsync_out", hsync_out, e_hs);
      check1("clamp_out", clamp_out, e_cl);
      check1("coast_out", coast_out, e_co);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n, input bit lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync_in = lvl;
    end
  endtask

  // Lines: active level for plen cycles out of every period.
  task automatic lines(input int cycles, input int period, input int plen,
                       input bit act, input bit mix);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      hsync_in = ((i % period) < plen) ? act : !act;
      if (mix) begin
        clamp_in = (i % 7) < 3;
        coast_in = (i % 11) < 4;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk_en = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    cur_req = "R1";
    check1("reset hsync_out", hsync_out, 1'b0);
    check1("reset clamp_out", clamp_out, 1'b0);
    check1("reset coast_out", coast_out, 1'b0);
    rst = 1'b0;
    lines(200, 50, 4, 1'b0, 1'b0);   // default width 16, delay 4, dur 8

    cur_req = "R11";
    idle(60, 1'b1);
    wr(2'd1, 8'd5); wr(2'd2, 8'd3); wr(2'd3, 8'd6);
    lines(200, 40, 3, 1'b0, 1'b0);

    cur_req = "R2";
    idle(60, 1'b1);
    wr(2'd0, 8'h1B);                 // rising edge leads
    idle(60, 1'b0);
    lines(200, 40, 9, 1'b1, 1'b0);

    cur_req = "R3";
    idle(60, 1'b0);
    wr(2'd1, 8'd1);
    lines(120, 30, 5, 1'b1, 1'b0);
    wr(2'd1, 8'd0);
    lines(120, 30, 5, 1'b1, 1'b0);

    cur_req = "R4";
    idle(60, 1'b0);
    wr(2'd1, 8'd6);
    wr(2'd0, 8'h19);                 // active-low output
    lines(200, 25, 3, 1'b1, 1'b0);

    cur_req = "R5";
    idle(60, 1'b0);
    wr(2'd0, 8'h1B);
    wr(2'd1, 8'd20);
    lines(200, 8, 2, 1'b1, 1'b0);

    cur_req = "R6";
    idle(60, 1'b0);
    wr(2'd1, 8'd4); wr(2'd2, 8'd7); wr(2'd3, 8'd5);
    lines(240, 40, 4, 1'b1, 1'b0);

    cur_req = "R7";
    idle(60, 1'b0);
    wr(2'd2, 8'd0); wr(2'd3, 8'd3);
    lines(160, 20, 4, 1'b1, 1'b0);
    idle(40, 1'b0);
    wr(2'd3, 8'd0);
    lines(160, 20, 4, 1'b1, 1'b0);

    cur_req = "R8";
    idle(60, 1'b0);
    wr(2'd2, 8'd10); wr(2'd3, 8'd10);
    lines(300, 12, 3, 1'b1, 1'b0);
    lines(200, 16, 3, 1'b1, 1'b0);

    cur_req = "R9";
    idle(60, 1'b0);
    wr(2'd0, 8'h1F);                 // external clamp, active high
    lines(200, 30, 4, 1'b1, 1'b1);
    wr(2'd0, 8'h17);                 // external clamp, active low
    lines(200, 30, 4, 1'b1, 1'b1);
    idle(60, 1'b0);
    wr(2'd0, 8'h13);                 // internal clamp: pin ignored
    lines(240, 30, 4, 1'b1, 1'b1);

    cur_req = "R10";
    lines(200, 30, 4, 1'b1, 1'b1);   // coast active high
    wr(2'd0, 8'h03);                 // coast active low
    lines(200, 30, 4, 1'b1, 1'b1);

    idle(20, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule